// File: doc/BRIEF.md
# Six-State Snooping Coherence Controller

This block tracks the coherence state of every line in a small direct-mapped cache attached to a snooping bus. The lines can be Invalid, Shared, Forward, Exclusive, Owned or Modified. Each cycle it can accept one event for one address. An event is either a request from the local processor (read, write, evict) or a transaction snooped from the bus (read, write, upgrade). For each event it reports the state the addressed line ends in, the bus transaction the cache must issue, whether this cache must supply the data to another cache, whether the line must be written back to memory, and whether the event was illegal for the line's current state.

Two of the states split responsibility between the holders of a line. An Owned line is dirty while other caches hold Shared copies of it, and its holder owes memory the write-back. A Forward line is clean, and its holder is the one cache that answers fill requests from other caches. When a local read misses, the line is filled in Forward if the bus shared-line signal shows other copies and in Exclusive if it does not. The block stores only a tag and a state for each set. Data storage, bus arbitration and memory timing belong to the surrounding logic.

Top module: `moesif_snoop_ctrl`

## Requirements
- R1: States appear on rsp_state as I=0, S=1, F=2, E=3, O=4, M=5. rsp_bus_req encodes 0 none, 1 read, 2 write (fetch for ownership), 3 upgrade. evt_kind encodes 0 local read, 1 local write, 2 local evict, 3 bus read, 4 bus write, 5 bus upgrade. Kinds 6 and 7 raise rsp_error and change nothing. After reset every line is I and rsp_valid is 0.
- R2: A local read (kind 0) whose set is I issues a bus read. It fills the line in E when bus_shared is 0 and in F when bus_shared is 1.
- R3: A local read that hits a valid line issues no bus request and leaves the state unchanged.
- R4: A local write (kind 1) behaves as follows. On an I set it issues a bus write and ends in M. In S, F or O it issues a bus upgrade and ends in M. In E it moves to M silently. In M it does nothing.
- R5: A bus read (kind 3) that hits a valid line behaves as follows. M moves to O and supplies. O stays O and supplies. E moves to F and supplies. F moves to S and supplies. S stays S with no action.
- R6: A bus write (kind 4) that hits a valid line invalidates it. It asserts rsp_supply when the line was M, O, E or F, and takes no action when the line was S.
- R7: A bus upgrade (kind 5) that hits a valid line behaves as follows. S and F move to I with no action. O moves to I with rsp_writeback. In M or E the upgrade is illegal: it raises rsp_error and the state is kept.
- R8: A local evict (kind 2) of a valid line moves it to I. It raises rsp_writeback from M or O and takes no action from S, F or E.
- R9: An evict of a line that is not present is an error. So is a local read or write to a set holding a valid line with a different tag. On an error, no bus request, supply or write-back is raised and the stored line is not changed.
- R10: A bus event for an address that is not present (set is I, or its tag differs) takes no action, reports I, and leaves the stored line untouched.
- R11: The result of an event is valid in the cycle after the edge that accepts it: rsp_valid is 1 exactly then and 0 otherwise. Sets are independent of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | An event is presented this cycle |
| evt_kind | input | 3 | Event code (see R1) |
| evt_addr | input | ADDR_W | Line address: upper bits tag, lower IDX_W bits set index |
| bus_shared | input | 1 | Other caches hold the line (used on a read fill) |
| rsp_valid | output | 1 | Response for the previous cycle's event |
| rsp_state | output | 3 | State of the addressed line after the event |
| rsp_bus_req | output | 2 | Bus transaction to issue |
| rsp_supply | output | 1 | Supply the line cache-to-cache |
| rsp_writeback | output | 1 | Write the line back to memory |
| rsp_error | output | 1 | Event illegal in the current state |

## Verification
Every result of this block is due exactly one clock after the edge that accepts its event. The response register is the only stage between the event inputs and the outputs, and the tag/state array is written at that same edge, so the next event already sees the new state. The bench drives each event on a falling edge and compares all five response fields at the following falling edge, against a model array that it updates at that same point. Effects on the array that the ports do not show directly, such as an untouched line after an error or a foreign snoop, are checked through a later local read that must hit without a bus request.

// File: rtl/moesif_pkg.sv
package moesif_pkg;

  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_F = 3'd2,
    ST_E = 3'd3,
    ST_O = 3'd4,
    ST_M = 3'd5
  } line_st_t;

  typedef enum logic [1:0] {
    BR_NONE  = 2'd0,
    BR_READ  = 2'd1,
    BR_WRITE = 2'd2,
    BR_UPG   = 2'd3
  } bus_req_t;

  localparam logic [2:0] EV_LOC_RD  = 3'd0;
  localparam logic [2:0] EV_LOC_WR  = 3'd1;
  localparam logic [2:0] EV_LOC_EVC = 3'd2;
  localparam logic [2:0] EV_BUS_RD  = 3'd3;
  localparam logic [2:0] EV_BUS_WR  = 3'd4;
  localparam logic [2:0] EV_BUS_UPG = 3'd5;

  typedef struct packed {
    line_st_t st;
    bus_req_t req;
    logic     supply;
    logic     wback;
    logic     err;
  } coh_resp_t;

endpackage

// File: rtl/moesif_tag_array.sv
module moesif_tag_array
  import moesif_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output line_st_t         rd_st,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  line_st_t         wr_st
);

  localparam int SETS = 1 << IDX_W;

  line_st_t         st_vec  [SETS];
  logic [TAG_W-1:0] tag_vec [SETS];

  for (genvar g = 0; g < SETS; g++) begin : g_set
    line_st_t         st_q;
    logic [TAG_W-1:0] tag_q;
    logic             sel;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= ST_I;
      end else if (sel) begin
        st_q <= wr_st;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q <= wr_tag;
      end
    end

    assign st_vec[g]  = st_q;
    assign tag_vec[g] = tag_q;
  end

  assign rd_st  = st_vec[rd_idx];
  assign rd_tag = tag_vec[rd_idx];

endmodule

// File: rtl/moesif_next.sv
module moesif_next
  import moesif_pkg::*;
(
  input  logic [2:0] kind,
  input  line_st_t   cur_st,
  input  logic       tag_hit,
  input  logic       shared,
  output coh_resp_t  resp,
  output logic       upd
);

  logic     present;
  logic     foreign;
  line_st_t eff;

  assign present = tag_hit && (cur_st != ST_I);
  assign foreign = !tag_hit && (cur_st != ST_I);
  assign eff     = present ? cur_st : ST_I;

  always_comb begin
    resp.st     = eff;
    resp.req    = BR_NONE;
    resp.supply = 1'b0;
    resp.wback  = 1'b0;
    resp.err    = 1'b0;
    upd         = 1'b0;
    case (kind)
      EV_LOC_RD: begin
        if (foreign) begin
          resp.err = 1'b1;
        end else if (!present) begin
          resp.req = BR_READ;
          resp.st  = shared ? ST_F : ST_E;
          upd      = 1'b1;
        end
      end
      EV_LOC_WR: begin
        if (foreign) begin
          resp.err = 1'b1;
        end else begin
          case (eff)
            ST_I: begin
              resp.req = BR_WRITE;
              resp.st  = ST_M;
              upd      = 1'b1;
            end
            ST_S, ST_F, ST_O: begin
              resp.req = BR_UPG;
              resp.st  = ST_M;
              upd      = 1'b1;
            end
            ST_E: begin
              resp.st = ST_M;
              upd     = 1'b1;
            end
            default: ;
          endcase
        end
      end
      EV_LOC_EVC: begin
        if (!present) begin
          resp.err = 1'b1;
        end else begin
          resp.wback = (eff == ST_M) || (eff == ST_O);
          resp.st    = ST_I;
          upd        = 1'b1;
        end
      end
      EV_BUS_RD: begin
        if (present) begin
          case (eff)
            ST_M: begin resp.st = ST_O; resp.supply = 1'b1; upd = 1'b1; end
            ST_O: begin resp.supply = 1'b1; end
            ST_E: begin resp.st = ST_F; resp.supply = 1'b1; upd = 1'b1; end
            ST_F: begin resp.st = ST_S; resp.supply = 1'b1; upd = 1'b1; end
            default: ;
          endcase
        end
      end
      EV_BUS_WR: begin
        if (present) begin
          resp.supply = (eff != ST_S);
          resp.st     = ST_I;
          upd         = 1'b1;
        end
      end
      EV_BUS_UPG: begin
        if (present) begin
          if ((eff == ST_M) || (eff == ST_E)) begin
            resp.err = 1'b1;
          end else begin
            resp.wback = (eff == ST_O);
            resp.st    = ST_I;
            upd        = 1'b1;
          end
        end
      end
      default: resp.err = 1'b1;
    endcase
  end

endmodule

// File: rtl/moesif_resp_reg.sv
module moesif_resp_reg
  import moesif_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  coh_resp_t resp_d,
  output logic      valid_q,
  output coh_resp_t resp_q
);

  logic      valid_d;
  coh_resp_t nxt;

  always_comb begin
    valid_d = load;
    nxt     = resp_q;
    if (load) begin
      nxt = resp_d;
    end else begin
      nxt.req    = BR_NONE;
      nxt.supply = 1'b0;
      nxt.wback  = 1'b0;
      nxt.err    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      resp_q  <= '{st: ST_I, req: BR_NONE, supply: 1'b0, wback: 1'b0, err: 1'b0};
    end else begin
      valid_q <= valid_d;
      resp_q  <= nxt;
    end
  end

  // R11
  idle_no_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> (resp_q.req == BR_NONE) && !resp_q.supply && !resp_q.wback && !resp_q.err);

endmodule

// File: rtl/moesif_snoop_ctrl.sv
module moesif_snoop_ctrl
  import moesif_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [2:0]        evt_kind,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic              bus_shared,
  output logic              rsp_valid,
  output logic [2:0]        rsp_state,
  output logic [1:0]        rsp_bus_req,
  output logic              rsp_supply,
  output logic              rsp_writeback,
  output logic              rsp_error
);

  localparam int TAG_W = ADDR_W - IDX_W;

  logic rst_meta, rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic [TAG_W-1:0] line_tag;
  line_st_t         line_st;
  coh_resp_t        resp_d, resp_q;
  logic             upd;

  assign idx = evt_addr[IDX_W-1:0];
  assign tag = evt_addr[ADDR_W-1:IDX_W];

  moesif_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
    .clk    (clk),
    .rst_n  (rst_q),
    .rd_idx (idx),
    .rd_tag (line_tag),
    .rd_st  (line_st),
    .wr_en  (evt_valid && upd),
    .wr_idx (idx),
    .wr_tag (tag),
    .wr_st  (resp_d.st)
  );

  moesif_next u_next (
    .kind    (evt_kind),
    .cur_st  (line_st),
    .tag_hit (line_tag == tag),
    .shared  (bus_shared),
    .resp    (resp_d),
    .upd     (upd)
  );

  moesif_resp_reg u_resp (
    .clk     (clk),
    .rst_n   (rst_q),
    .load    (evt_valid),
    .resp_d  (resp_d),
    .valid_q (rsp_valid),
    .resp_q  (resp_q)
  );

  assign rsp_state     = resp_q.st;
  assign rsp_bus_req   = resp_q.req;
  assign rsp_supply    = resp_q.supply;
  assign rsp_writeback = resp_q.wback;
  assign rsp_error     = resp_q.err;

  // R1
  state_code_chk: assert property (@(posedge clk) disable iff (!rst_q)
    rsp_state <= 3'd5);

  // R4
  upgrade_ends_m_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rsp_bus_req == 2'd3) |-> (rsp_state == 3'd5));

  // R8
  wback_leaves_i_chk: assert property (@(posedge clk) disable iff (!rst_q)
    rsp_writeback |-> (rsp_state == 3'd0) && !rsp_supply);

  // R9
  error_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    rsp_error |-> (rsp_bus_req == 2'd0) && !rsp_supply && !rsp_writeback);

  // R5
  supply_on_snoop_chk: assert property (@(posedge clk) disable iff (!rst_q)
    rsp_supply |-> ($past(evt_kind) == 3'd3) || ($past(evt_kind) == 3'd4));

  // R11
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_q)
    evt_valid |=> rsp_valid);

endmodule

// File: tb/moesif_snoop_ctrl_test.sv
module moesif_snoop_ctrl_test;

  localparam int ADDR_W = 8;
  localparam int IDX_W  = 2;
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int SETS   = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              evt_valid;
  logic [2:0]        evt_kind;
  logic [ADDR_W-1:0] evt_addr;
  logic              bus_shared;
  logic              rsp_valid;
  logic [2:0]        rsp_state;
  logic [1:0]        rsp_bus_req;
  logic              rsp_supply;
  logic              rsp_writeback;
  logic              rsp_error;

  int checks = 0;
  int errors = 0;

  logic [2:0]       m_st  [SETS];
  logic [TAG_W-1:0] m_tag [SETS];

  always #4 clk = ~clk;

  moesif_snoop_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .evt_addr(evt_addr), .bus_shared(bus_shared), .rsp_valid(rsp_valid),
    .rsp_state(rsp_state), .rsp_bus_req(rsp_bus_req), .rsp_supply(rsp_supply),
    .rsp_writeback(rsp_writeback), .rsp_error(rsp_error)
  );

  // packed expectation: {upd, st[2:0], req[1:0], sup, wb, err}
  function automatic logic [8:0] expect_of(input logic [2:0] k, input logic [2:0] cur,
                                           input logic hit, input logic sh);
    logic [2:0] e, s;
    logic [1:0] r;
    logic sp, wb, er, up;
    logic pres, forn;
    pres = hit && cur != 3'd0;
    forn = !hit && cur != 3'd0;
    e = pres ? cur : 3'd0;
    s = e; r = 2'd0; sp = 0; wb = 0; er = 0; up = 0;
    if (k == 3'd0) begin
      if (forn) er = 1;
      else if (!pres) begin r = 2'd1; s = sh ? 3'd2 : 3'd3; up = 1; end
    end else if (k == 3'd1) begin
      if (forn) er = 1;
      else if (e == 3'd0) begin r = 2'd2; s = 3'd5; up = 1; end
      else if (e == 3'd1 || e == 3'd2 || e == 3'd4) begin r = 2'd3; s = 3'd5; up = 1; end
      else if (e == 3'd3) begin s = 3'd5; up = 1; end
    end else if (k == 3'd2) begin
      if (!pres) er = 1;
      else begin wb = (e == 3'd5 || e == 3'd4); s = 3'd0; up = 1; end
    end else if (k == 3'd3) begin
      if (e == 3'd5) begin s = 3'd4; sp = 1; up = 1; end
      else if (e == 3'd4) sp = 1;
      else if (e == 3'd3) begin s = 3'd2; sp = 1; up = 1; end
      else if (e == 3'd2) begin s = 3'd1; sp = 1; up = 1; end
    end else if (k == 3'd4) begin
      if (pres) begin sp = (e != 3'd1); s = 3'd0; up = 1; end
    end else if (k == 3'd5) begin
      if (pres) begin
        if (e == 3'd5 || e == 3'd3) er = 1;
        else begin wb = (e == 3'd4); s = 3'd0; up = 1; end
      end
    end else begin
      er = 1;
    end
    return {up, s, r, sp, wb, er};
  endfunction

  function automatic string req_name(input logic [2:0] k, input logic err, input logic hit,
                                     input logic [2:0] cur);
    if (k > 3'd5) return "R1";
    if (err) return "R9";
    if (k >= 3'd3 && !(hit && cur != 3'd0)) return "R10";
    case (k)
      3'd0: return (hit && cur != 3'd0) ? "R3" : "R2";
      3'd1: return "R4";
      3'd2: return "R8";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic event_chk(input logic [2:0] k, input logic [ADDR_W-1:0] a, input logic sh);
    logic [IDX_W-1:0] ix;
    logic [TAG_W-1:0] tg;
    logic [8:0] ex;
    logic hit;
    string rq;
    ix = a[IDX_W-1:0];
    tg = a[ADDR_W-1:IDX_W];
    hit = (m_tag[ix] == tg);
    ex = expect_of(k, m_st[ix], hit, sh);
    rq = req_name(k, ex[0], hit, m_st[ix]);
    evt_valid = 1'b1; evt_kind = k; evt_addr = a; bus_shared = sh;
    @(negedge clk);
    checks++;
    if ({1'b1, rsp_state, rsp_bus_req, rsp_supply, rsp_writeback, rsp_error} != {1'b1, ex[7:0]}
        || !rsp_valid) begin
      errors++;
      $display("FAIL %s kind=%0d addr=%h: got v=%b st=%0d req=%0d sup=%b wb=%b err=%b, expected v=1 st=%0d req=%0d sup=%b wb=%b err=%b",
               rq, k, a, rsp_valid, rsp_state, rsp_bus_req, rsp_supply, rsp_writeback, rsp_error,
               ex[7:5], ex[4:3], ex[2], ex[1], ex[0]);
    end
    if (ex[8]) begin
      m_st[ix]  = ex[7:5];
      m_tag[ix] = tg;
    end
    evt_valid = 1'b0;
  endtask

  task automatic idle_chk();
    @(negedge clk);
    checks++;
    if (rsp_valid || rsp_bus_req != 0 || rsp_supply || rsp_writeback || rsp_error) begin
      errors++;
      $display("FAIL R11 idle: got v=%b req=%0d sup=%b wb=%b err=%b, expected all 0",
               rsp_valid, rsp_bus_req, rsp_supply, rsp_writeback, rsp_error);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int t, input int i);
    return {TAG_W'(t), IDX_W'(i)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got no finish, expected end of run");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < SETS; i++) begin m_st[i] = 3'd0; m_tag[i] = '0; end
    rst_n = 1'b0; evt_valid = 1'b0; evt_kind = '0; evt_addr = '0; bus_shared = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid || rsp_error) begin
      errors++;
      $display("FAIL R1 reset: got v=%b err=%b, expected 0 0", rsp_valid, rsp_error);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    idle_chk();
    // R2 fills: E with shared low, F with shared high
    event_chk(3'd0, mk(1, 0), 1'b0);
    event_chk(3'd0, mk(2, 1), 1'b1);
    // R3 hit
    event_chk(3'd0, mk(1, 0), 1'b1);
    // R4 E->M silent, then R5 M->O supply, O stays O
    event_chk(3'd1, mk(1, 0), 1'b0);
    event_chk(3'd3, mk(1, 0), 1'b0);
    event_chk(3'd3, mk(1, 0), 1'b0);
    // R7 upgrade in O -> I with write-back
    event_chk(3'd5, mk(1, 0), 1'b0);
    // R5 F->S, R4 S upgrade to M, R8 evict M
    event_chk(3'd3, mk(2, 1), 1'b0);
    event_chk(3'd1, mk(2, 1), 1'b0);
    event_chk(3'd2, mk(2, 1), 1'b0);
    // R4 write miss, R7 upgrade in M is an error, R10 foreign snoop
    event_chk(3'd1, mk(3, 2), 1'b0);
    event_chk(3'd5, mk(3, 2), 1'b0);
    event_chk(3'd4, mk(4, 2), 1'b0);
    // R9 conflicting local read, bad evict, then line still M
    event_chk(3'd0, mk(4, 2), 1'b0);
    event_chk(3'd2, mk(5, 3), 1'b0);
    event_chk(3'd0, mk(3, 2), 1'b0);
    // R6 bus write on M supplies; R1 illegal kind
    event_chk(3'd4, mk(3, 2), 1'b0);
    event_chk(3'd6, mk(3, 2), 1'b0);
    event_chk(3'd7, mk(3, 2), 1'b0);
    idle_chk();
    // R11 random mix of kinds, tags and shared
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] k;
      k = ($urandom_range(0, 19) == 0) ? 3'($urandom_range(6, 7)) : 3'($urandom_range(0, 5));
      event_chk(k, mk($urandom_range(0, 1), $urandom_range(0, SETS - 1)), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 7) == 0) idle_chk();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule